// File: doc/BRIEF.md
# Interrupt Request and Count/Compare Timer Unit

This unit is the interrupt-request slice of a processor's system-control coprocessor. It merges five external hardware interrupt lines, two software-owned interrupt bits and a free-running count/compare timer into one vector of pending bits. It then qualifies that vector with a per-bit mask and with the processor's global enable, exception-level and error-level flags, and raises a single registered take-interrupt request for the pipeline. The timer's match flag shares a pending bit with the fifth hardware line.

Software reaches the unit through a small register port: a write strobe, a 2-bit register select and 32-bit write data, plus a registered read-data bus. Four registers are visible: count, compare, status and cause. The unit also reports whether the core is in kernel mode, derived from the status flags. It does not choose among exceptions or produce vector addresses; it only requests an interrupt and shows the pending bits.

Top module: `irq_timer_ctrl`

## Requirements
- R1: After synchronous reset, count reads 0, compare reads 0xFFFFFFFF, status reads 0x00000004 (only the error-level flag set), irq_pending is 0, irq_take is 0 and kernel_mode is 1.
- R2: Register select 0 is count. A write loads it, and after that it advances by one on every second clock edge. The first increment comes on the second edge after the write.
- R3: The timer flag is set on the edge after one where count equals compare. It stays set while count moves on or is rewritten, and a write to compare (select 1) is the only thing that clears it.
- R4: Hardware line i (0 to 4) appears at pending bit i+2 one clock after it is sampled, with no latching. A one-cycle pulse shows for exactly one cycle.
- R5: Pending bit 6 is the OR of hardware line 4 and the timer flag.
- R6: Pending bits 1:0 are the software bits. A write to cause (select 3) loads them from write-data bits 9:8 and ignores every other bit. Between writes they hold their value.
- R7: irq_take is registered. It is 1 exactly when, in the previous cycle, global enable was 1, exception level and error level were both 0, and some pending bit ANDed with its mask bit was nonzero.
- R8: Status (select 2) has global enable at bit 0, exception level at bit 1, error level at bit 2, user flag at bit 4 and mask bits 14:8, with mask bit 8+k gating pending bit k. All other bits read 0.
- R9: Cause reads the live pending vector at bits 14:8 with every other bit 0. reg_rdata shows the selected register one clock after reg_addr is presented.
- R10: kernel_mode is 1 when the user flag is 0 or when exception level or error level is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | 5 | External interrupt lines, level sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 count, 1 compare, 2 status, 3 cause |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| irq_pending | output | 7 | Registered pending vector: software bits 1:0, hardware bits 6:2 |
| irq_take | output | 1 | Registered take-interrupt request |
| kernel_mode | output | 1 | Core is in kernel mode |

## Verification
Every cycle, the assertions check several rules. Count never steps by more than one. A compare write always clears the timer flag, and a match always sets it. The software bits stay put unless cause is written. The hardware pending bits track the lines one cycle late. Any blocking flag forces irq_take low, and irq_take never rises without a masked pending bit. Only the bench scenarios can show the exact two-cycle count cadence and the cycle on which a timer match reaches the pending output. They also cover the status and cause read encodings, the per-line mask routing, the kernel-mode decode and the reset values.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_STATUS  = 2'd2,
    SEL_CAUSE   = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_IE    = 0;
  localparam int unsigned BIT_EXL   = 1;
  localparam int unsigned BIT_ERL   = 2;
  localparam int unsigned BIT_USER  = 4;
  localparam int unsigned FIELD_LSB = 8;
endpackage

// File: rtl/irq_count_timer.sv
module irq_count_timer #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_wr,
  input  logic          cmp_wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] compare_o,
  output logic          timer_pend_o
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      phase_q <= 1'b0;
    end else if (cnt_wr) begin
      count_o <= wdata;
      phase_q <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) count_o <= count_o + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) compare_o <= '1;
    else if (cmp_wr) compare_o <= wdata;
  end

  // compare write wins over a match seen on the same edge
  always_ff @(posedge clk) begin
    if (rst) timer_pend_o <= 1'b0;
    else if (cmp_wr) timer_pend_o <= 1'b0;
    else if (count_o == compare_o) timer_pend_o <= 1'b1;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CW'(1)));

  assert_timer_clear_R3: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> !timer_pend_o);

  assert_timer_set_R3: assert property (@(posedge clk) disable iff (rst)
    (!cmp_wr && count_o == compare_o) |=> timer_pend_o);
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
  parameter int unsigned PW = 7,
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_wr,
  input  logic          cause_wr,
  input  logic          ie_d,
  input  logic          exl_d,
  input  logic          erl_d,
  input  logic          user_d,
  input  logic [PW-1:0] mask_d,
  input  logic [SW-1:0] sw_d,
  output logic          ie_o,
  output logic          exl_o,
  output logic          erl_o,
  output logic          user_o,
  output logic [PW-1:0] mask_o,
  output logic [SW-1:0] sw_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_o   <= 1'b0;
      exl_o  <= 1'b0;
      erl_o  <= 1'b1;
      user_o <= 1'b0;
      mask_o <= '0;
    end else if (st_wr) begin
      ie_o   <= ie_d;
      exl_o  <= exl_d;
      erl_o  <= erl_d;
      user_o <= user_d;
      mask_o <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sw_o <= '0;
    else if (cause_wr) sw_o <= sw_d;
  end

  assert_sw_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cause_wr |=> $stable(sw_o));
endmodule

// File: rtl/irq_pending_unit.sv
module irq_pending_unit #(
  parameter int unsigned HW = 5,
  parameter int unsigned SW = 2,
  localparam int unsigned PW = HW + SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hw_irq,
  input  logic [SW-1:0] sw,
  input  logic          timer_pend,
  input  logic [PW-1:0] mask,
  input  logic          ie,
  input  logic          exl,
  input  logic          erl,
  output logic [PW-1:0] pend_now_o,
  output logic [PW-1:0] pend_q_o,
  output logic          take_o
);
  assign pend_now_o[SW-1:0] = sw;

  for (genvar i = 0; i < HW; i++) begin : g_hw
    if (i == HW - 1) begin : g_shared
      assign pend_now_o[SW+i] = hw_irq[i] | timer_pend;
    end else begin : g_plain
      assign pend_now_o[SW+i] = hw_irq[i];
    end
  end

  logic take_d;
  assign take_d = ie & ~exl & ~erl & (|(pend_now_o & mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q_o <= '0;
      take_o   <= 1'b0;
    end else begin
      pend_q_o <= pend_now_o;
      take_o   <= take_d;
    end
  end

  assert_hw_follow_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pend_q_o[PW-2:SW] == $past(hw_irq[HW-2:0]));

  assert_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (!ie || exl || erl) |=> !take_o);

  assert_take_masked_R7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> |(pend_q_o & $past(mask)));
endmodule

// File: rtl/irq_timer_ctrl.sv
module irq_timer_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned HW = 5,
  parameter int unsigned SW = 2,
  parameter int unsigned DW = 32,
  localparam int unsigned PW = HW + SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hw_irq,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [PW-1:0] irq_pending,
  output logic          irq_take,
  output logic          kernel_mode
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  logic cnt_wr, cmp_wr, st_wr, cause_wr;
  assign cnt_wr   = reg_wr && sel == SEL_COUNT;
  assign cmp_wr   = reg_wr && sel == SEL_COMPARE;
  assign st_wr    = reg_wr && sel == SEL_STATUS;
  assign cause_wr = reg_wr && sel == SEL_CAUSE;

  logic [DW-1:0] count, compare;
  logic          timer_pend;
  logic          ie, exl, erl, user;
  logic [PW-1:0] mask, pend_now;
  logic [SW-1:0] sw;

  irq_count_timer #(.CW(DW)) u_timer (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .wdata(reg_wdata),
    .count_o(count), .compare_o(compare), .timer_pend_o(timer_pend)
  );

  irq_status_regs #(.PW(PW), .SW(SW)) u_status (
    .clk(clk), .rst(rst), .st_wr(st_wr), .cause_wr(cause_wr),
    .ie_d(reg_wdata[BIT_IE]), .exl_d(reg_wdata[BIT_EXL]), .erl_d(reg_wdata[BIT_ERL]),
    .user_d(reg_wdata[BIT_USER]), .mask_d(reg_wdata[FIELD_LSB +: PW]),
    .sw_d(reg_wdata[FIELD_LSB +: SW]),
    .ie_o(ie), .exl_o(exl), .erl_o(erl), .user_o(user), .mask_o(mask), .sw_o(sw)
  );

  irq_pending_unit #(.HW(HW), .SW(SW)) u_pend (
    .clk(clk), .rst(rst), .hw_irq(hw_irq), .sw(sw), .timer_pend(timer_pend),
    .mask(mask), .ie(ie), .exl(exl), .erl(erl),
    .pend_now_o(pend_now), .pend_q_o(irq_pending), .take_o(irq_take)
  );

  assign kernel_mode = ~user | exl | erl;

  logic [DW-1:0] st_word, cause_word, rd_d;
  always_comb begin
    st_word = '0;
    st_word[BIT_IE]   = ie;
    st_word[BIT_EXL]  = exl;
    st_word[BIT_ERL]  = erl;
    st_word[BIT_USER] = user;
    st_word[FIELD_LSB +: PW] = mask;
    cause_word = '0;
    cause_word[FIELD_LSB +: PW] = pend_now;
    unique case (sel)
      SEL_COUNT:   rd_d = count;
      SEL_COMPARE: rd_d = compare;
      SEL_STATUS:  rd_d = st_word;
      default:     rd_d = cause_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else reg_rdata <= rd_d;
  end

  assert_kernel_R10: assert property (@(posedge clk) disable iff (rst)
    (exl || erl) |-> kernel_mode);
endmodule

// File: tb/sim_irq_timer_ctrl.sv
module sim_irq_timer_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  hw_irq = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  irq_pending;
  logic        irq_take;
  logic        kernel_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_timer_ctrl u0 (
    .clk(clk), .rst(rst), .hw_irq(hw_irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pending(irq_pending),
    .irq_take(irq_take), .kernel_mode(kernel_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); check("R1 count", v, 32'h0);
    rd(2'd1, v); check("R1 compare", v, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R1 status", v, 32'h4);
    check("R1 pending", {25'd0, irq_pending}, 32'h0);
    check("R1 take", {31'd0, irq_take}, 32'h0);
    check("R1 kernel", {31'd0, kernel_mode}, 32'h1);
  endtask

  task automatic t_status();
    logic [31:0] v;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R8 status fields", v, 32'h0000_7F17);
    check("R10 kernel with exl", {31'd0, kernel_mode}, 32'h1);
    wr(2'd2, 32'h10);
    check("R10 user mode", {31'd0, kernel_mode}, 32'h0);
    wr(2'd2, 32'h14);
    check("R10 user with erl", {31'd0, kernel_mode}, 32'h1);
    wr(2'd2, 32'h0);
    check("R10 kernel flag clear", {31'd0, kernel_mode}, 32'h1);
  endtask

  task automatic t_count();
    logic [31:0] v;
    logic [31:0] exp [5] = '{32'd100, 32'd100, 32'd101, 32'd101, 32'd102};
    wr(2'd0, 32'd100);
    for (int i = 0; i < 5; i++) begin
      rd(2'd0, v); check("R2 count cadence", v, exp[i]);
    end
  endtask

  task automatic t_mask();
    for (int k = 0; k < 5; k++) begin
      hw_irq = 5'(1 << k);
      wr(2'd2, 32'h1 | (32'h1 << (8 + 2 + k)));
      @(negedge clk);
      check(k == 4 ? "R5 line4 at bit6" : "R4 line position",
            {25'd0, irq_pending}, 32'h1 << (2 + k));
      check("R7 masked take", {31'd0, irq_take}, 32'h1);
      wr(2'd2, 32'h1 | (32'h1 << (8 + ((k + 3) % 7))));
      @(negedge clk);
      check("R7 other mask blocks", {31'd0, irq_take}, 32'h0);
    end
    hw_irq = '0;
    @(negedge clk);
    hw_irq = 5'h1;
    @(negedge clk);
    hw_irq = '0;
    check("R4 pulse seen", {25'd0, irq_pending}, 32'h4);
    @(negedge clk);
    check("R4 pulse not latched", {25'd0, irq_pending}, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    wr(2'd0, 32'd0);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R6 R9 cause read", v, 32'h0000_0300);
    check("R6 pending sw", {25'd0, irq_pending}, 32'h3);
    wr(2'd2, 32'h1 | (32'h1 << 9));
    @(negedge clk);
    check("R6 sw1 take", {31'd0, irq_take}, 32'h1);
    wr(2'd3, 32'h0000_0000);
    @(negedge clk);
    check("R6 sw cleared take", {31'd0, irq_take}, 32'h0);
    rd(2'd3, v); check("R6 cause cleared", v, 32'h0);
  endtask

  task automatic t_block();
    hw_irq = 5'h1;
    wr(2'd2, 32'h7F03);
    @(negedge clk);
    check("R7 exl blocks", {31'd0, irq_take}, 32'h0);
    wr(2'd2, 32'h7F01);
    @(negedge clk);
    check("R7 exl released", {31'd0, irq_take}, 32'h1);
    wr(2'd2, 32'h7F05);
    @(negedge clk);
    check("R7 erl blocks", {31'd0, irq_take}, 32'h0);
    wr(2'd2, 32'h7F00);
    @(negedge clk);
    check("R7 ie clear blocks", {31'd0, irq_take}, 32'h0);
    hw_irq = '0;
  endtask

  task automatic t_timer();
    wr(2'd2, 32'h1 | (32'h1 << 14));
    wr(2'd1, 32'd20);
    wr(2'd0, 32'd10);
    repeat (21) @(negedge clk);
    check("R3 no early match", {25'd0, irq_pending}, 32'h0);
    @(negedge clk);
    check("R3 R5 match on bit6", {25'd0, irq_pending}, 32'h40);
    check("R3 timer take", {31'd0, irq_take}, 32'h1);
    repeat (10) @(negedge clk);
    check("R3 flag holds", {25'd0, irq_pending}, 32'h40);
    wr(2'd0, 32'd0);
    @(negedge clk);
    check("R3 count write keeps flag", {25'd0, irq_pending}, 32'h40);
    wr(2'd1, 32'd1000);
    @(negedge clk);
    check("R3 compare write clears", {25'd0, irq_pending}, 32'h0);
    check("R3 take drops", {31'd0, irq_take}, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_status();
    t_count();
    t_mask();
    t_soft();
    t_block();
    t_timer();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule